// File: doc/BRIEF.md
# Saturated Cell Redirect Table

This block sits beside an array of multi-level memory cells that are programmed without erasing. Each cell stores one logical bit as the parity of its charge level. To flip a bit, the controller raises the level by one step. After LEVELS-1 steps a cell is at its top level and cannot change again until the page is erased. The block decides, for every write, whether the cell must be raised one step or whether a replacement entry is needed. It keeps a small fully associative table of redirect entries, and each entry pairs a saturated cell's address with the bit that cell should now read as.

On a read, the controller supplies the address and the current level of the cell. The block returns the level's low bit, unless an active entry matches the address; in that case it returns the entry's stored bit. On a write, the controller supplies the address, the wanted bit and the cell's present level. The block then does one of four things: it asserts a one-cycle bump command to the array, it updates an entry in place, it claims the lowest-numbered free entry, or it refuses the write and raises a sticky erase-needed flag. A page erase empties the table and clears the flag.

Top module: `sat_ptr_table`

## Requirements
- R1: A read of an address with no active entry returns bit 0 of the supplied level (odd levels read as 1, even levels read as 0).
- R2: A read of an address that holds an active entry returns that entry's stored bit, whatever level is supplied.
- R3: A write to an address with no active entry, whose level is below LEVELS-1 and whose level parity differs from the written bit, asserts bump_cell in the same cycle. If the parity already equals the written bit, bump_cell stays low and the table does not change.
- R4: A write to an address with no active entry, at level LEVELS-1 and with parity different from the written bit, never bumps the cell. It stores the address and bit in the lowest-numbered free entry, and a read of that address returns the bit from the next cycle onward.
- R5: A write to an address that already holds an active entry replaces that entry's bit, claims no new entry and never asserts bump_cell, whatever the level.
- R6: When R4 would claim an entry but none is free, the write changes nothing. erase_req goes high on the following cycle and stays high until an erase.
- R7: An erase clears every entry and erase_req by the next cycle. A write presented in the same cycle as an erase is ignored and does not bump.
- R8: A write at level LEVELS-1 whose parity already equals the written bit claims no entry and does not bump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase | input | 1 | Page erase: clears all entries and erase_req |
| rd_addr | input | ADDR_W | Cell address to read |
| rd_level | input | LVL_W | Present level of the cell being read |
| rd_bit | output | 1 | Logical bit of the cell being read |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | ADDR_W | Cell address to write |
| wr_bit | input | 1 | Bit to store |
| wr_level | input | LVL_W | Present level of the cell being written |
| bump_cell | output | 1 | Array must raise the written cell by one level this cycle |
| erase_req | output | 1 | Sticky: a write was refused because the table is full |

## Verification
The bench goes after the level boundary, where a write at LEVELS-2 must still bump while a write at LEVELS-1 must divert to the table. A design with an off-by-one at this boundary would bump a saturated cell or waste an entry. The bench also rewrites an address that already has an entry. A design that searched only for free entries would use a second entry there, fill the table early and then raise erase_req on a later write. Further cases are a write refused when the table is full, which must leave the old read value in place, and a write issued together with an erase, which a design that gave priority to the write would still turn into a bump. Random traffic over a small address range then mixes all of these against a behavioural model.

// File: rtl/sptr_pkg.sv
package sptr_pkg;
   typedef enum logic [2:0] {
      ACT_IDLE,
      ACT_BUMP,
      ACT_UPDATE,
      ACT_ALLOC,
      ACT_REJECT
   } wr_act_e;
endpackage

// File: rtl/sptr_cam.sv
module sptr_cam #(
   parameter int NUM_PTR = 100,
   parameter int ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic               upd_en,
   input  logic               alloc_en,
   input  logic [NUM_PTR-1:0] alloc_sel,
   input  logic               new_bit,
   output logic               rd_hit,
   output logic               rd_val,
   output logic [NUM_PTR-1:0] wr_hit_vec,
   output logic [NUM_PTR-1:0] valid_vec
);
   logic [NUM_PTR-1:0] rd_hit_vec;
   logic [NUM_PTR-1:0] bit_vec;

   for (genvar i = 0; i < NUM_PTR; i++) begin : g_ent
      logic [ADDR_W-1:0] tag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_vec[i] <= 1'b0;
            tag_q        <= '0;
            bit_vec[i]   <= 1'b0;
         end else if (clear) begin
            valid_vec[i] <= 1'b0;
         end else if (upd_en && wr_hit_vec[i]) begin
            bit_vec[i]   <= new_bit;
         end else if (alloc_en && alloc_sel[i]) begin
            valid_vec[i] <= 1'b1;
            tag_q        <= wr_addr;
            bit_vec[i]   <= new_bit;
         end
      end
      assign rd_hit_vec[i] = valid_vec[i] && (tag_q == rd_addr);
      assign wr_hit_vec[i] = valid_vec[i] && (tag_q == wr_addr);
   end

   assign rd_hit = |rd_hit_vec;
   assign rd_val = |(rd_hit_vec & bit_vec);
endmodule

// File: rtl/sptr_alloc.sv
module sptr_alloc #(
   parameter int NUM_PTR = 100
) (
   input  logic [NUM_PTR-1:0] valid_vec,
   output logic [NUM_PTR-1:0] grant,
   output logic               any_free
);
   logic [NUM_PTR-1:0] plus_one;
   assign plus_one = valid_vec + NUM_PTR'(1);
   assign grant    = ~valid_vec & plus_one;
   assign any_free = ~&valid_vec;
endmodule

// File: rtl/sptr_wctl.sv
module sptr_wctl
   import sptr_pkg::*;
#(
   parameter int LEVELS = 8,
   parameter int LVL_W  = 3
) (
   input  logic             wr_en,
   input  logic             erase,
   input  logic             wr_bit,
   input  logic [LVL_W-1:0] wr_level,
   input  logic             hit,
   input  logic             any_free,
   output wr_act_e          act
);
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

   logic at_top;
   logic need_flip;
   assign at_top    = (wr_level == TOP_LVL);
   assign need_flip = (wr_level[0] != wr_bit);

   always_comb begin
      act = ACT_IDLE;
      if (wr_en && !erase) begin
         if (hit)             act = ACT_UPDATE;
         else if (!need_flip) act = ACT_IDLE;
         else if (!at_top)    act = ACT_BUMP;
         else if (any_free)   act = ACT_ALLOC;
         else                 act = ACT_REJECT;
      end
   end
endmodule

// File: rtl/sat_ptr_table.sv
module sat_ptr_table
   import sptr_pkg::*;
#(
   parameter int NUM_PTR = 100,
   parameter int ADDR_W  = 12,
   parameter int LEVELS  = 8,
   localparam int LVL_W  = (LEVELS > 2) ? $clog2(LEVELS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [LVL_W-1:0]  rd_level,
   output logic              rd_bit,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_bit,
   input  logic [LVL_W-1:0]  wr_level,
   output logic              bump_cell,
   output logic              erase_req
);
   if (LEVELS < 2) begin : g_bad_lvl
      $error("LEVELS must be at least 2");
   end
   if (NUM_PTR < 1) begin : g_bad_ptr
      $error("NUM_PTR must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   logic               rd_hit;
   logic               rd_val;
   logic [NUM_PTR-1:0] wr_hit_vec;
   logic [NUM_PTR-1:0] valid_vec;
   logic [NUM_PTR-1:0] grant;
   logic               any_free;
   wr_act_e            act;
   logic               do_alloc;
   logic               do_update;

   assign do_alloc  = (act == ACT_ALLOC);
   assign do_update = (act == ACT_UPDATE);

   sptr_cam #(.NUM_PTR(NUM_PTR), .ADDR_W(ADDR_W)) u_cam (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (erase),
      .rd_addr    (rd_addr),
      .wr_addr    (wr_addr),
      .upd_en     (do_update),
      .alloc_en   (do_alloc),
      .alloc_sel  (grant),
      .new_bit    (wr_bit),
      .rd_hit     (rd_hit),
      .rd_val     (rd_val),
      .wr_hit_vec (wr_hit_vec),
      .valid_vec  (valid_vec)
   );

   sptr_alloc #(.NUM_PTR(NUM_PTR)) u_alloc (
      .valid_vec (valid_vec),
      .grant     (grant),
      .any_free  (any_free)
   );

   sptr_wctl #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_wctl (
      .wr_en    (wr_en),
      .erase    (erase),
      .wr_bit   (wr_bit),
      .wr_level (wr_level),
      .hit      (|wr_hit_vec),
      .any_free (any_free),
      .act      (act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                erase_req <= 1'b0;
      else if (erase)            erase_req <= 1'b0;
      else if (act == ACT_REJECT) erase_req <= 1'b1;
   end

   assign bump_cell = (act == ACT_BUMP);
   assign rd_bit    = rd_hit ? rd_val : rd_level[0];
endmodule

// File: rtl/sat_ptr_table_chk.sv
module sat_ptr_table_chk #(
   parameter int NUM_PTR = 100,
   parameter int LEVELS  = 8,
   parameter int LVL_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               erase,
   input logic               wr_en,
   input logic               wr_bit,
   input logic [LVL_W-1:0]   wr_level,
   input logic               bump_cell,
   input logic               erase_req,
   input logic               do_alloc,
   input logic [NUM_PTR-1:0] valid_vec,
   input logic [NUM_PTR-1:0] wr_hit_vec
);
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

   // R3
   bump_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bump_cell |-> (wr_level[0] != wr_bit));
   // R4
   bump_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bump_cell |-> (wr_level != TOP_LVL));
   // R4
   alloc_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_alloc |=> (valid_vec == $past(valid_vec | (valid_vec + NUM_PTR'(1)))));
   // R5
   single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_hit_vec));
   // R5
   hit_no_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (|wr_hit_vec)) |-> !bump_cell);
   // R6
   ereq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req && !erase) |=> erase_req);
   // R7
   erase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> (!erase_req && (valid_vec == '0)));
   // R7
   erase_no_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase |-> !bump_cell);
endmodule

bind sat_ptr_table sat_ptr_table_chk #(
   .NUM_PTR (NUM_PTR),
   .LEVELS  (LEVELS),
   .LVL_W   (LVL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .erase      (erase),
   .wr_en      (wr_en),
   .wr_bit     (wr_bit),
   .wr_level   (wr_level),
   .bump_cell  (bump_cell),
   .erase_req  (erase_req),
   .do_alloc   (do_alloc),
   .valid_vec  (valid_vec),
   .wr_hit_vec (wr_hit_vec)
);

// File: tb/sat_ptr_table_test.sv
module sat_ptr_table_test;
   localparam int NP = 4;
   localparam int AW = 5;
   localparam int LV = 4;
   localparam int LW = 2;
   localparam int TOP = LV - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          erase = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [LW-1:0] rd_level = '0;
   logic          rd_bit;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic          wr_bit = 1'b0;
   logic [LW-1:0] wr_level = '0;
   logic          bump_cell;
   logic          erase_req;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   bit  ref_map [int];
   bit  ref_ereq = 1'b0;

   always #5 clk = ~clk;

   sat_ptr_table #(.NUM_PTR(NP), .ADDR_W(AW), .LEVELS(LV)) uut (
      .clk(clk), .rst_n(rst_n), .erase(erase),
      .rd_addr(rd_addr), .rd_level(rd_level), .rd_bit(rd_bit),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit), .wr_level(wr_level),
      .bump_cell(bump_cell), .erase_req(erase_req)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit we, input int a, input bit b, input int lvl,
                       input bit er, input int ra, input int rl, input string tag);
      bit exp_rd;
      bit exp_bump;
      wr_en = we; wr_addr = AW'(a); wr_bit = b; wr_level = LW'(lvl);
      erase = er; rd_addr = AW'(ra); rd_level = LW'(rl);
      #4;
      exp_rd   = ref_map.exists(ra) ? ref_map[ra] : bit'(rl % 2);
      exp_bump = 1'b0;
      if (we && !er && !ref_map.exists(a) && (bit'(lvl % 2) != b) && lvl < TOP)
         exp_bump = 1'b1;
      check(ref_map.exists(ra) ? "R2" : "R1", "rd_bit", int'(rd_bit), int'(exp_rd));
      check(tag, "bump_cell", int'(bump_cell), int'(exp_bump));
      check(ref_ereq ? "R6" : tag, "erase_req", int'(erase_req), int'(ref_ereq));
      @(posedge clk);
      if (er) begin
         ref_map.delete();
         ref_ereq = 1'b0;
      end else if (we) begin
         if (ref_map.exists(a))            ref_map[a] = b;
         else if (bit'(lvl % 2) == b)      ;
         else if (lvl < TOP)               ;
         else if (ref_map.num() < NP)      ref_map[a] = b;
         else                              ref_ereq = 1'b1;
      end
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      step(0, 0, 0, 0, 0, 3, 1, "R1");       // reset state, odd level reads 1
      step(1, 1, 1, 0, 0, 1, 2, "R3");       // parity differs: bump
      step(1, 1, 0, 2, 0, 1, 2, "R3");       // parity equal: no bump
      step(1, 1, 1, TOP-1, 0, 1, 2, "R3");   // one below top still bumps
      step(1, 2, 0, TOP, 0, 2, TOP, "R4");   // saturated flip: allocate
      step(0, 0, 0, 0, 0, 2, TOP, "R2");     // redirected read gives 0
      step(1, 3, 1, TOP, 0, 3, TOP, "R8");   // saturated, already 1
      step(0, 0, 0, 0, 0, 3, TOP, "R8");
      step(1, 4, 0, TOP, 0, 0, 0, "R4");
      step(1, 5, 0, TOP, 0, 0, 0, "R4");
      step(1, 2, 1, 0, 0, 0, 0, "R5");       // update in place, no bump
      step(0, 0, 0, 0, 0, 2, TOP, "R5");
      step(1, 6, 0, TOP, 0, 6, TOP, "R4");   // last free entry
      step(1, 9, 0, TOP, 0, 9, TOP, "R6");   // table full: refused
      step(0, 0, 0, 0, 0, 9, TOP, "R6");     // erase_req high, read unchanged
      step(1, 2, 0, 0, 0, 2, TOP, "R6");     // updates still allowed when full
      step(1, 10, 1, 0, 1, 4, TOP, "R7");    // erase wins over write
      step(0, 0, 0, 0, 0, 4, TOP, "R7");     // entry gone, erase_req low
      step(0, 0, 0, 0, 0, 10, 0, "R7");
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 10) < 8, $urandom % 8, 1'($urandom), $urandom % LV,
              ($urandom % 50) == 0, $urandom % 8, $urandom % LV, "R3");
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule